// File: doc/BRIEF.md
# Dual-Speed 1-Wire Slave ROM Command Layer

This block is the ROM-function layer of a 1-Wire slave that can run at two bus speeds. A bit-level front end reports every bus reset, and whether it was long or short, and hands over each received data bit as a one-cycle strobe. After each reset the block collects a command byte, least significant bit first. The byte either selects the device at once or starts a 64-bit identity comparison against a build-time parameter.

The block keeps the overdrive flag that the timing front end reads to choose its slot timing. The two overdrive commands set this flag. A short bus reset leaves it alone. A long reset clears it, and so does failing the overdrive identity match. The `selected` output enables the memory function layer above. The `locked` output shows that the device ignores all bus traffic until the next reset.

Top module: `onewire_rom_layer`

## Requirements
- R1: After `rst_n` is released, `selected`=0, `overdrive`=0 and `locked`=1. Data bits received before the first bus reset change none of these outputs.
- R2: A bus reset strobe (`bus_rst`=1), long or short, gives `selected`=0 and `locked`=0 on the next cycle. The block then waits for a new command byte.
- R3: A long bus reset (`bus_rst_long`=1 with `bus_rst`) clears `overdrive` on the next cycle. A short reset leaves `overdrive` unchanged.
- R4: Command byte 0x3C, received LSB first (the first bit received is bit 0), sets `selected`=1 and `overdrive`=1 in the cycle after its eighth bit.
- R5: Command byte 0xCC sets `selected`=1 in the cycle after its eighth bit and leaves `overdrive` unchanged.
- R6: Command byte 0x69 sets `overdrive`=1 in the cycle after its eighth bit. The next 64 bits are compared with `DEVICE_ID`, the i-th bit received against `DEVICE_ID[i]`. If all 64 bits are equal, `selected`=1 in the cycle after the 64th bit.
- R7: During a 0x69 identity comparison, the first unequal bit gives `locked`=1, `overdrive`=0 and `selected`=0 on the next cycle.
- R8: Command byte 0x55 compares 64 bits in the same way as R6 and leaves `overdrive` unchanged. A full match sets `selected`=1. The first unequal bit sets `locked`=1.
- R9: Any other command byte sets `locked`=1 in the cycle after its eighth bit, with `selected`=0 and `overdrive` unchanged.
- R10: While `selected` or `locked` is 1, data bits change none of the outputs until the next bus reset.
- R11: A bus reset and a data bit strobed in the same cycle act as the reset alone. The data bit is discarded.
- R12: `selected` and `locked` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle strobe: the front end saw a bus reset pulse |
| bus_rst_long | input | 1 | Qualifies `bus_rst`: the pulse reached the regular-speed reset length |
| bit_valid | input | 1 | One-cycle strobe: a data bit was received |
| bit_val | input | 1 | Value of the received data bit |
| overdrive | output | 1 | Speed flag for the front end: 1 selects overdrive timing |
| selected | output | 1 | The device is addressed; the memory function layer may run |
| locked | output | 1 | The device ignores the bus until the next reset |

## Verification
Every output is a register, so each result is due on the first clock edge that takes its triggering strobe. That strobe is the eighth command bit, the 64th identity bit, the first wrong identity bit, or a bus reset strobe. The bench drives each strobe on a falling edge and removes it on the next falling edge. It then samples the outputs on that second falling edge, exactly one rising edge after the trigger and before any later stimulus. Because the table vectors run back to back, the overdrive state carries from one vector to the next. This checks that short resets keep the flag and long resets clear it.

// File: rtl/onewire_rom_layer.sv
module onewire_rom_layer #(
  parameter int ID_BITS = 64,
  parameter int CMD_BITS = 8,
  parameter logic [ID_BITS-1:0] DEVICE_ID = 64'hA5C3_0F1E_7788_9B2D,
  parameter logic [CMD_BITS-1:0] OP_SKIP = 8'hCC,
  parameter logic [CMD_BITS-1:0] OP_MATCH = 8'h55,
  parameter logic [CMD_BITS-1:0] OP_OD_SKIP = 8'h3C,
  parameter logic [CMD_BITS-1:0] OP_OD_MATCH = 8'h69
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic bus_rst_long,
  input  logic bit_valid,
  input  logic bit_val,
  output logic overdrive,
  output logic selected,
  output logic locked
);
  localparam int CW = $clog2(ID_BITS);
  localparam logic [CW-1:0] ID_LAST = CW'(ID_BITS - 1);
  localparam logic [CW-1:0] CMD_LAST = CW'(CMD_BITS - 1);

  typedef enum logic [1:0] {S_LOCK, S_CMD, S_ID, S_SEL} state_t;

  state_t state;
  logic [CW-1:0] cnt;
  logic [CMD_BITS-2:0] cmd_sr;
  logic od_cmd;

  wire take = bit_valid && !bus_rst;
  wire [CMD_BITS-1:0] cmd_word = {bit_val, cmd_sr};
  wire id_miss = bit_val != DEVICE_ID[cnt];

  assign selected = (state == S_SEL);
  assign locked = (state == S_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_LOCK;
      cnt <= '0;
      cmd_sr <= '0;
      od_cmd <= 1'b0;
      overdrive <= 1'b0;
    end else if (bus_rst) begin
      state <= S_CMD;
      cnt <= '0;
      od_cmd <= 1'b0;
      if (bus_rst_long) overdrive <= 1'b0;
    end else if (take) begin
      case (state)
        S_CMD: begin
          cmd_sr <= cmd_word[CMD_BITS-1:1];
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            if (cmd_word == OP_OD_SKIP) begin
              state <= S_SEL;
              overdrive <= 1'b1;
            end else if (cmd_word == OP_SKIP) begin
              state <= S_SEL;
            end else if (cmd_word == OP_OD_MATCH) begin
              state <= S_ID;
              od_cmd <= 1'b1;
              overdrive <= 1'b1;
            end else if (cmd_word == OP_MATCH) begin
              state <= S_ID;
            end else begin
              state <= S_LOCK;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ID: begin
          if (id_miss) begin
            state <= S_LOCK;
            if (od_cmd) overdrive <= 1'b0;
          end else if (cnt == ID_LAST) begin
            state <= S_SEL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_rst_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !selected && !locked);
  p_long_rst_clears_od_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst && bus_rst_long |=> !overdrive);
  p_short_rst_keeps_od_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst && !bus_rst_long |=> overdrive == $past(overdrive));
  p_od_miss_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && state == S_ID && od_cmd && id_miss |=> locked && !overdrive);
  p_locked_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !bus_rst |=> locked && $stable(overdrive));
  p_selected_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    selected && !bus_rst |=> selected && $stable(overdrive));
  p_od_rise_needs_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdrive) |-> $past(bit_valid) && !$past(bus_rst));
  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(selected && locked));
endmodule

// File: tb/sim_onewire_rom_layer.sv
`timescale 1ns/1ps
module sim_onewire_rom_layer;
  localparam logic [63:0] ID = 64'hA5C3_0F1E_7788_9B2D;
  localparam int NV = 13;
  // {cmd[7:0], long, idmode[1:0] (0 none,1 full,2 flip at pos), pos[5:0], sel, od, lock}
  localparam logic [19:0] VEC [NV] = '{
    {8'hCC, 1'b1, 2'd0, 6'd0,  3'b100},
    {8'h3C, 1'b0, 2'd0, 6'd0,  3'b110},
    {8'hCC, 1'b0, 2'd0, 6'd0,  3'b110},
    {8'hCC, 1'b1, 2'd0, 6'd0,  3'b100},
    {8'h69, 1'b0, 2'd1, 6'd0,  3'b110},
    {8'h55, 1'b0, 2'd1, 6'd0,  3'b110},
    {8'h55, 1'b0, 2'd2, 6'd0,  3'b011},
    {8'h69, 1'b0, 2'd2, 6'd63, 3'b001},
    {8'h3C, 1'b0, 2'd0, 6'd0,  3'b110},
    {8'hF0, 1'b0, 2'd0, 6'd0,  3'b011},
    {8'h55, 1'b1, 2'd1, 6'd0,  3'b100},
    {8'h69, 1'b1, 2'd2, 6'd17, 3'b001},
    {8'h00, 1'b0, 2'd0, 6'd0,  3'b001}
  };

  logic clk = 0, rst_n = 0, bus_rst = 0, bus_rst_long = 0, bit_valid = 0, bit_val = 0;
  logic overdrive, selected, locked;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  onewire_rom_layer #(.DEVICE_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_rst_long(bus_rst_long),
    .bit_valid(bit_valid), .bit_val(bit_val),
    .overdrive(overdrive), .selected(selected), .locked(locked));

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({selected, overdrive, locked} !== exp) begin
      errors++;
      $display("FAIL %s: {sel,od,lock} actual %b expected %b", req, {selected, overdrive, locked}, exp);
    end
  endtask

  task automatic bus_reset(input logic lng);
    @(negedge clk); bus_rst = 1; bus_rst_long = lng;
    @(negedge clk); bus_rst = 0; bus_rst_long = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1; bit_val = b;
    @(negedge clk); bit_valid = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_id(input logic flip, input int pos);
    for (int i = 0; i < 64; i++) send_bit(ID[i] ^ (flip && i == pos));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'b001);
    rst_n = 1;
    send_byte(8'h3C);
    check("R1 bits before first bus reset ignored", 3'b001);

    for (int v = 0; v < NV; v++) begin
      bus_reset(VEC[v][11]);
      check("R2 after bus reset", {1'b0, VEC[v][11] ? 1'b0 : overdrive, 1'b0});
      send_byte(VEC[v][19:12]);
      if (VEC[v][10:9] != 2'd0) send_id(VEC[v][10:9] == 2'd2, int'(VEC[v][8:3]));
      check($sformatf("R4/R5/R6/R7/R8/R9/R3 vector %0d cmd %h", v, VEC[v][19:12]), VEC[v][2:0]);
    end

    bus_reset(1);
    send_byte(8'h69);
    check("R6 overdrive set right after 0x69 byte", 3'b010);
    send_id(0, 0);
    check("R6 full match selected", 3'b110);
    send_byte(8'hFF);
    send_byte(8'h00);
    check("R10 traffic ignored while selected", 3'b110);

    bus_reset(0);
    send_byte(8'h55);
    for (int i = 0; i < 5; i++) send_bit(ID[i]);
    send_bit(~ID[5]);
    check("R8 first wrong bit locks at once", 3'b011);
    send_byte(8'h3C);
    check("R10 traffic ignored while locked", 3'b011);

    bus_reset(1);
    for (int i = 0; i < 7; i++) send_bit(OP_bit(i));
    @(negedge clk); bus_rst = 1; bit_valid = 1; bit_val = 1'b0;
    @(negedge clk); bus_rst = 0; bit_valid = 0;
    check("R11 reset with bit discards bit", 3'b000);
    send_byte(8'h3C);
    check("R11 fresh command after reset", 3'b110);
    bus_reset(0);
    check("R3 short reset keeps overdrive", 3'b010);
    bus_reset(1);
    check("R3 long reset clears overdrive", 3'b000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic OP_bit(input int i);
    logic [7:0] b = 8'h3C;
    return b[i];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule